// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channel

This block is a single timer channel built around a 16-bit free-running counter and two general registers, called C and D. Each general register has its own pin pair. It works either as an output compare register or as an input capture register. In compare mode it acts on its output pin when the counter reaches its value. In capture mode it stores the counter value when a chosen edge arrives on its input pin. An 8-bit I/O control register holds a 3-bit code for each general register. The code selects the role and the action.

Software reaches the control register, the counter, both general registers and the event flags through a small address/data port. Writes take effect at the clock edge. Reads are combinational. Each general register has a sticky event flag, which is also brought out as a port. A compare match or a qualifying capture sets the flag. Writing 0 to the flag's bit clears it.

Address map on `addr`:
- 0: control register.
- 1: counter.
- 2: general register C.
- 3: general register D.
- 4: flags, with bit 0 for C and bit 1 for D.
- Any other address reads as zero.

Top module: `dual_ccr_timer`

## Requirements
- R1: After reset the control register reads 0x88. Bits 7 and 3 always read as 1, whatever value is written to them.
- R2: Control bits 2:0 are the code for register C (pin index 0). Control bits 6:4 are the code for register D (pin index 1). An event on one register never changes the other register's pin, flag or value.
- R3: The counter increments by one on every clock with `cnt_en` high and wraps from 0xFFFF to 0. It holds its value while `cnt_en` is low. A write to address 1 loads it.
- R4: A code with bit 2 equal to 0 selects compare mode. A match is a cycle with `cnt_en` high and the counter equal to the register value. On the clock edge that ends the match cycle, the register's flag is set.
- R5: Compare code 000 leaves the pin unchanged on a match.
- R6: On a match, compare code 001 drives the pin to 0 and compare code 010 drives it to 1.
- R7: On every match, compare code 011 inverts the pin.
- R8: Capture code 100 loads the counter into the register and sets the flag on a rising pin edge only. A falling edge is ignored.
- R9: Capture code 101 captures on a falling pin edge only. A rising edge is ignored.
- R10: Capture codes 110 and 111 both capture on either pin edge.
- R11: The capture input passes through a two-flop synchronizer. Suppose the pin changes in a cycle whose counter value is V and the counter is running. The captured value is then V+2, visible three clock edges later.
- R12: Flags are sticky. Writing 1 to a flag bit leaves it unchanged. Writing 0 clears it. If an event and a clearing write fall in the same cycle, the flag ends set.
- R13: Output pins reset to 0. `pin_oe` is high only while the code selects compare mode with a nonzero code. In capture mode the output pin holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter count enable |
| addr | input | 3 | Register port address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data (combinational) |
| pin_in | input | 2 | Capture pins, bit 0 for C, bit 1 for D |
| pin_out | output | 2 | Compare output pins |
| pin_oe | output | 2 | Output enables for the compare pins |
| flag | output | 2 | Sticky match/capture flags |

## Verification
The hardest case to reach is a flag-clearing write that lands in the very cycle the counter equals a general register. The bench parks the counter three counts below the target and enables counting on a known falling clock edge. It then issues the clearing write exactly three cycles later. The capture sweeps read the running counter in the cycle the pin is moved, so the V+2 synchronizer offset can be predicted exactly. Every code is swept on both registers, each with a rising edge followed by a falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [7:0] CTRL_RESET = 8'h88;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CNT  = 3'd1;
    localparam logic [2:0] A_GR0  = 3'd2;
    localparam logic [2:0] A_FLAG = 3'd4;

    typedef enum logic [2:0] {
        OC_NONE  = 3'b000,
        OC_LOW   = 3'b001,
        OC_HIGH  = 3'b010,
        OC_TGL   = 3'b011,
        IC_RISE  = 3'b100,
        IC_FALL  = 3'b101,
        IC_BOTH  = 3'b110,
        IC_BOTHX = 3'b111
    } io_code_e;

    typedef struct packed {
        logic is_cap;
        logic out_en;
        logic on_rise;
        logic on_fall;
    } io_dec_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic io_dec_t decode_io(input logic [2:0] code);
        io_dec_t d;
        d.is_cap  = code[2];
        d.out_en  = !code[2] && (code[1:0] != 2'b00);
        d.on_rise = code[2] && (code[1] || !code[0]);
        d.on_fall = code[2] && (code[1] || code[0]);
        return d;
    endfunction

endpackage

// File: rtl/free_cnt.sv
module free_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)     cnt <= '0;
        else if (ld) cnt <= ld_val;
        else if (en) cnt <= cnt + W'(1);
    end

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !ld) |=> (cnt == $past(cnt) + W'(1)));

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!en && !ld) |=> $stable(cnt));
endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t ev
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign ev.rise = sh[STAGES-1] & ~sh[STAGES];
    assign ev.fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/gr_unit.sv
module gr_unit
    import tmr_pkg::*;
#(
    parameter int W = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [W-1:0] GR_RESET = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic [W-1:0] cnt,
    input  logic [2:0]   code,
    input  logic         gr_we,
    input  logic [W-1:0] gr_wdata,
    input  logic         flag_clr,
    input  logic         pin_in,
    output logic [W-1:0] gr_q,
    output logic         flag,
    output logic         pin_out,
    output logic         pin_oe
);
    io_dec_t dec;
    edge_t   ev;
    logic    match;
    logic    cap;

    pin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(pin_in), .ev(ev)
    );

    assign dec    = decode_io(code);
    assign match  = !dec.is_cap && cnt_en && (cnt == gr_q);
    assign cap    = (dec.on_rise && ev.rise) || (dec.on_fall && ev.fall);
    assign pin_oe = dec.out_en;

    always_ff @(posedge clk) begin
        if (rst)        gr_q <= GR_RESET;
        else if (cap)   gr_q <= cnt;
        else if (gr_we) gr_q <= gr_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out <= 1'b0;
        end else if (match) begin
            unique case (io_code_e'(code))
                OC_LOW:  pin_out <= 1'b0;
                OC_HIGH: pin_out <= 1'b1;
                OC_TGL:  pin_out <= ~pin_out;
                default: pin_out <= pin_out;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                flag <= 1'b0;
        else if (match || cap)  flag <= 1'b1;
        else if (flag_clr)      flag <= 1'b0;
    end

    p_cap_load_r8: assert property (@(posedge clk) disable iff (rst)
        cap |=> (gr_q == $past(cnt)));

    p_event_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (match || cap) |=> flag);

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (match && code == 3'b011) |=> (pin_out != $past(pin_out)));

    p_cap_pin_hold_r13: assert property (@(posedge clk) disable iff (rst)
        code[2] |=> $stable(pin_out));
endmodule

// File: rtl/dual_ccr_timer.sv
module dual_ccr_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic [1:0]       pin_in,
    output logic [1:0]       pin_out,
    output logic [1:0]       pin_oe,
    output logic [1:0]       flag
);
    localparam int N_CH = 2;
    localparam int FLD_STRIDE = 4;

    logic [CNT_W-1:0] cnt;
    logic [2:0]       fld [N_CH];
    logic [CNT_W-1:0] gr  [N_CH];
    logic [7:0]       ctrl_rd;

    free_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(cnt_en),
        .ld(wr_en && addr == A_CNT), .ld_val(wr_data), .cnt(cnt)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                fld[i] <= CTRL_RESET[FLD_STRIDE*i +: 3];
            else if (wr_en && addr == A_CTRL)
                fld[i] <= wr_data[FLD_STRIDE*i +: 3];
        end

        gr_unit #(.W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_gr (
            .clk      (clk),
            .rst      (rst),
            .cnt_en   (cnt_en),
            .cnt      (cnt),
            .code     (fld[i]),
            .gr_we    (wr_en && addr == A_GR0 + 3'(i)),
            .gr_wdata (wr_data),
            .flag_clr (wr_en && addr == A_FLAG && !wr_data[i]),
            .pin_in   (pin_in[i]),
            .gr_q     (gr[i]),
            .flag     (flag[i]),
            .pin_out  (pin_out[i]),
            .pin_oe   (pin_oe[i])
        );
    end

    assign ctrl_rd = {1'b1, fld[1], 1'b1, fld[0]};

    always_comb begin
        rd_data = '0;
        unique case (addr)
            3'd0:    rd_data = CNT_W'(ctrl_rd);
            3'd1:    rd_data = cnt;
            3'd2:    rd_data = gr[0];
            3'd3:    rd_data = gr[1];
            3'd4:    rd_data = CNT_W'(flag);
            default: rd_data = '0;
        endcase
    end

    p_ctrl_rsv_r1: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTRL) |-> (rd_data[7] && rd_data[3]));

    p_oe_mode_r13: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[0] |-> !rd_data_ctrl_cap(ctrl_rd, 0)) and
        (pin_oe[1] |-> !rd_data_ctrl_cap(ctrl_rd, 1)));

    function automatic logic rd_data_ctrl_cap(input logic [7:0] c, input int ch);
        return c[FLD_STRIDE*ch + 2];
    endfunction
endmodule

// File: tb/dual_ccr_timer_test.sv
module dual_ccr_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic [1:0]  pin_in = 2'b00;
    logic [1:0]  pin_out;
    logic [1:0]  pin_oe;
    logic [1:0]  flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_ccr_timer uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=finish", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] v0;
        logic [1:0]  exp_pin;

        wait_neg(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R13 reset state
        rd(3'd0, v); chk("R1", "ctrl reset", v, 16'h0088);
        chk("R13", "pin_out reset", pin_out, 2'b00);
        chk("R13", "pin_oe reset", pin_oe, 2'b00);
        chk("R12", "flag reset", flag, 2'b00);
        rd(3'd1, v); chk("R3", "cnt reset", v, 16'h0000);

        // R1 reserved bits
        wr(3'd0, 16'h0000); rd(3'd0, v); chk("R1", "ctrl wr 00", v, 16'h0088);
        wr(3'd0, 16'h00FF); rd(3'd0, v); chk("R1", "ctrl wr FF", v, 16'h00FF);
        wr(3'd0, 16'h0051); rd(3'd0, v); chk("R1", "ctrl wr 51", v, 16'h00D9);
        wr(3'd0, 16'h0000);

        // R3 counter load / hold / count / wrap
        wr(3'd1, 16'h1234); wait_neg(5);
        rd(3'd1, v); chk("R3", "cnt hold", v, 16'h1234);
        cnt_en = 1'b1; wait_neg(10); cnt_en = 1'b0;
        rd(3'd1, v); chk("R3", "cnt +10", v, 16'h123E);
        wr(3'd1, 16'hFFFE); cnt_en = 1'b1; wait_neg(3); cnt_en = 1'b0;
        rd(3'd1, v); chk("R3", "cnt wrap", v, 16'h0001);

        // R4-R7 compare sweep on both channels
        exp_pin = 2'b00;
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < 7; s++) begin
                logic [2:0]  code;
                logic [15:0] g;
                logic        oth_pin;
                code = (s == 0) ? 3'd0 : (s == 1) ? 3'd2 : (s == 2) ? 3'd1 :
                       (s == 3) ? 3'd2 : (s == 4) ? 3'd0 : 3'd3;
                g = 16'h0100 + 16'(ch * 16 + s);
                wr(3'd0, 16'(code) << (ch * 4));
                chk("R13", "oe compare code", 32'(pin_oe[ch]), 32'(code != 3'd0));
                chk("R2", "other oe", 32'(pin_oe[1-ch]), 32'd0);
                wr(3'd2 + 3'(1 - ch), 16'hF000);
                wr(3'd2 + 3'(ch), g);
                wr(3'd1, g - 16'd3);
                wr(3'd4, 16'h0000);
                oth_pin = pin_out[1-ch];
                cnt_en = 1'b1;
                wait_neg(3);
                chk("R4", "flag before match", 32'(flag[ch]), 32'd0);
                @(negedge clk);
                cnt_en = 1'b0;
                case (code)
                    3'd1: exp_pin[ch] = 1'b0;
                    3'd2: exp_pin[ch] = 1'b1;
                    3'd3: exp_pin[ch] = ~exp_pin[ch];
                    default: exp_pin[ch] = exp_pin[ch];
                endcase
                chk("R4", "flag after match", 32'(flag[ch]), 32'd1);
                if (code == 3'd3)      chk("R7", "toggle pin", 32'(pin_out[ch]), 32'(exp_pin[ch]));
                else if (code == 3'd0) chk("R5", "no-op pin", 32'(pin_out[ch]), 32'(exp_pin[ch]));
                else                   chk("R6", "drive pin", 32'(pin_out[ch]), 32'(exp_pin[ch]));
                chk("R2", "other flag", 32'(flag[1-ch]), 32'd0);
                chk("R2", "other pin", 32'(pin_out[1-ch]), 32'(oth_pin));
            end
        end

        // R12 flag clear collides with match, then write-1 / write-0
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0200);
        wr(3'd3, 16'hF000);
        wr(3'd1, 16'h01FD);
        wr(3'd4, 16'h0000);
        cnt_en = 1'b1;
        wait_neg(3);
        addr = 3'd4; wr_data = 16'h0000; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        chk("R12", "event beats clear", 32'(flag[0]), 32'd1);
        wr(3'd4, 16'h0003); chk("R12", "write 1 keeps", 32'(flag[0]), 32'd1);
        wr(3'd4, 16'h0000); chk("R12", "write 0 clears", 32'(flag[0]), 32'd0);

        // R8-R11 capture sweep, running counter
        cnt_en = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            for (int c = 4; c < 8; c++) begin
                wr(3'd0, 16'(c) << (ch * 4));
                chk("R13", "oe capture code", 32'(pin_oe[ch]), 32'd0);
                for (int e = 0; e < 2; e++) begin
                    logic        hit;
                    logic [15:0] exp_gr;
                    string       rq;
                    wr(3'd2 + 3'(ch), 16'hAAAA);
                    wr(3'd4, 16'h0000);
                    hit = (c >= 6) || (c == 4 && e == 0) || (c == 5 && e == 1);
                    rq  = (c >= 6) ? "R10" : (c == 4) ? "R8" : "R9";
                    @(negedge clk);
                    rd(3'd1, v0);
                    pin_in[ch] = (e == 0);
                    wait_neg(3);
                    exp_gr = hit ? v0 + 16'd2 : 16'hAAAA;
                    rd(3'd2 + 3'(ch), v);
                    chk(rq, "capture value", v, exp_gr);
                    chk("R11", "sync latency", 32'(v == v0 + 16'd2), 32'(hit));
                    chk(rq, "capture flag", 32'(flag[ch]), 32'(hit));
                    chk("R2", "other flag cap", 32'(flag[1-ch]), 32'd0);
                    chk("R13", "pin held in capture", 32'(pin_out[ch]), 32'(exp_pin[ch]));
                end
            end
            wr(3'd0, 16'h0000);
        end
        cnt_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule